// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer of 18-bit words whose write side and read side each run on their own clock. A word is stored on every write-clock rising edge while the active-low write strobe is low, and a new word is presented on every read-clock rising edge while the active-low read strobe is low. Writes into a full buffer and reads from an empty one are refused. After a refused read the output keeps the last word that was really read.

Five active-low flags report the fill state: empty, full, more than half full, almost empty and almost full. The write-side flags are computed in the write domain. The read-side flags are computed in the read domain. The pointers cross between the domains in gray code through two-flop synchronizers. Two 12-bit threshold registers set the almost-empty and almost-full distances, and both reset to 7. While the active-low load control is low, write strobes store the low 12 data bits into these registers in turn, and read strobes return them on the output in the same turn. An active-low output enable forces the output word to zero when it is high.

The offset registers are meant to be changed only while no traffic is flowing. The read domain uses them directly, without a synchronizer.

Top module: `dcfifo_prog`

## Requirements
- R1: A reset pulse (rst_n low, held for several edges of both clocks) leaves empty_n=0, full_n=1, half_n=1, aempty_n=0, afull_n=1 and dout=0. Write and read strobes given while rst_n is low store nothing.
- R2: With load_n=1, words come out on dout in the order they were written, one word per read-clock edge that has rd_en_n=0 while the buffer is not empty. dout changes at that same edge.
- R3: A write attempt (wr_en_n=0, load_n=1) while full_n=0 stores nothing. The write pointer does not move, and the word never appears on the read side.
- R4: A read attempt while empty_n=0 does not move the read pointer, and dout keeps the last word that was read.
- R5: full_n is 0 exactly when the write side sees DEPTH stored words. empty_n is 0 when the read side sees zero stored words. The stored count never exceeds DEPTH, and each pointer's gray code changes by at most one bit per edge.
- R6: half_n is 0 while the write-side count is greater than DEPTH/2, and 1 otherwise.
- R7: aempty_n is 0 while the read-side count is less than or equal to the empty offset. The empty offset resets to 7.
- R8: afull_n is 0 while the write-side count is greater than or equal to DEPTH minus the full offset. The full offset resets to 7.
- R9: Each write-clock edge with load_n=0 and wr_en_n=0 stores din[11:0] into one offset register. The order is empty offset, then full offset, then back to the empty offset. The position in this order is kept while load_n is high, and an edge with load_n=0 and wr_en_n=1 changes nothing.
- R10: Each read-clock edge with load_n=0 and rd_en_n=0 puts one offset register on dout[11:0], with dout[17:12]=0. The order is empty offset, then full offset, and it wraps in the same way.
- R11: While oe_n=1, dout is all zero. When oe_n returns to 0, the held word reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low read strobe |
| load_n | input | 1 | Active-low offset register access select |
| oe_n | input | 1 | Active-low output enable |
| din | input | 18 | Write data; bits 11:0 carry offset values |
| dout | output | 18 | Read data, or offset readback |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_n | output | 1 | Low when more than half full (write domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
Suppose a pointer advances on a refused strobe, or the gray code crosses the domains badly. The read side then sees a word that was never written, or loses one. The scoreboard reports this on the first read that falls out of step, within a handful of read-clock edges. Count or threshold errors move a flag by one word. Each flag is therefore checked on both sides of its boundary, a few synchronizer edges after the last write. An offset register that is out of step in its load order shows up at once in the readback value.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int WORD_W = 18;
  localparam int OFS_W  = 12;
  localparam logic [OFS_W-1:0] OFS_DEFAULT = 12'd7;

  typedef enum logic {OFS_EMPTY, OFS_FULL} ofs_sel_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_MEM, SRC_OFS} rd_src_e;
endpackage

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] gray_out,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      gray_out <= '0;
    end else begin
      stage1   <= gray_in;
      gray_out <= stage1;
    end
  end

  always_comb begin
    bin_out[PW-1] = gray_out[PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ gray_out[i];
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int SW   = ((OFS_W > PW) ? OFS_W : PW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              load_n,
  input  logic [WORD_W-1:0] din,
  input  logic [PW-1:0]     rq_bin,
  output logic              push,
  output logic [AW-1:0]     waddr,
  output logic [PW-1:0]     w_bin,
  output logic [PW-1:0]     w_gray,
  output logic [PW-1:0]     w_cnt,
  output logic              full,
  output logic              half,
  output logic              afull,
  output logic [OFS_W-1:0]  ofs_empty,
  output logic [OFS_W-1:0]  ofs_full
);
  ofs_sel_e      sel;
  logic [PW-1:0] bin_nx, cnt_nx;

  assign push   = !wr_en_n && load_n && !full;
  assign bin_nx = w_bin + PW'(push);
  assign cnt_nx = bin_nx - rq_bin;
  assign waddr  = w_bin[AW-1:0];
  assign w_cnt  = w_bin - rq_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
      full   <= 1'b0;
      half   <= 1'b0;
      afull  <= 1'b0;
    end else begin
      w_bin  <= bin_nx;
      w_gray <= bin_nx ^ (bin_nx >> 1);
      full   <= cnt_nx == PW'(DEPTH);
      half   <= cnt_nx > PW'(DEPTH / 2);
      afull  <= (SW'(cnt_nx) + SW'(ofs_full)) >= SW'(DEPTH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= OFS_EMPTY;
      ofs_empty <= OFS_DEFAULT;
      ofs_full  <= OFS_DEFAULT;
    end else if (!load_n && !wr_en_n) begin
      if (sel == OFS_EMPTY) ofs_empty <= din[OFS_W-1:0];
      else                  ofs_full  <= din[OFS_W-1:0];
      sel <= (sel == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
    end
  end
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int SW   = ((OFS_W > PW) ? OFS_W : PW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_n,
  input  logic              load_n,
  input  logic [PW-1:0]     wq_bin,
  input  logic [OFS_W-1:0]  ofs_empty,
  input  logic [OFS_W-1:0]  ofs_full,
  input  logic [WORD_W-1:0] mem_q,
  output logic              pop,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     r_bin,
  output logic [PW-1:0]     r_gray,
  output logic              empty,
  output logic              aempty,
  output logic [WORD_W-1:0] rdata
);
  ofs_sel_e         sel;
  rd_src_e          src;
  logic [OFS_W-1:0] ofs_q;
  logic [PW-1:0]    bin_nx, cnt_nx;

  assign pop    = !rd_en_n && load_n && !empty;
  assign bin_nx = r_bin + PW'(pop);
  assign cnt_nx = wq_bin - bin_nx;
  assign raddr  = r_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      r_bin  <= bin_nx;
      r_gray <= bin_nx ^ (bin_nx >> 1);
      empty  <= cnt_nx == '0;
      aempty <= SW'(cnt_nx) <= SW'(ofs_empty);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel   <= OFS_EMPTY;
      src   <= SRC_NONE;
      ofs_q <= '0;
    end else if (!load_n && !rd_en_n) begin
      ofs_q <= (sel == OFS_EMPTY) ? ofs_empty : ofs_full;
      sel   <= (sel == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
      src   <= SRC_OFS;
    end else if (pop) begin
      src   <= SRC_MEM;
    end
  end

  always_comb begin
    unique case (src)
      SRC_MEM: rdata = mem_q;
      SRC_OFS: rdata = {{(WORD_W-OFS_W){1'b0}}, ofs_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic              load_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);
  logic              push, pop, full, half, afull, empty, aempty;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     w_bin, w_gray, w_cnt, r_bin, r_gray;
  logic [PW-1:0]     rq_gray, rq_bin, wq_gray, wq_bin;
  logic [OFS_W-1:0]  ofs_empty, ofs_full;
  logic [WORD_W-1:0] mem_q, rdata;

  dcfifo_wr_side #(.DEPTH(DEPTH)) i_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n), .din(din),
    .rq_bin(rq_bin), .push(push), .waddr(waddr), .w_bin(w_bin), .w_gray(w_gray),
    .w_cnt(w_cnt), .full(full), .half(half), .afull(afull),
    .ofs_empty(ofs_empty), .ofs_full(ofs_full)
  );

  dcfifo_rd_side #(.DEPTH(DEPTH)) i_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .load_n(load_n),
    .wq_bin(wq_bin), .ofs_empty(ofs_empty), .ofs_full(ofs_full), .mem_q(mem_q),
    .pop(pop), .raddr(raddr), .r_bin(r_bin), .r_gray(r_gray),
    .empty(empty), .aempty(aempty), .rdata(rdata)
  );

  dcfifo_ram #(.DW(WORD_W), .DEPTH(DEPTH)) i_ram (
    .wr_clk(wr_clk), .we(push), .waddr(waddr), .wdata(din),
    .rd_clk(rd_clk), .re(pop), .raddr(raddr), .rdata(mem_q)
  );

  dcfifo_ptr_sync #(.PW(PW)) i_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(r_gray), .gray_out(rq_gray), .bin_out(rq_bin)
  );

  dcfifo_ptr_sync #(.PW(PW)) i_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(w_gray), .gray_out(wq_gray), .bin_out(wq_bin)
  );

  assign dout     = oe_n ? '0 : rdata;
  assign empty_n  = !empty;
  assign full_n   = !full;
  assign half_n   = !half;
  assign aempty_n = !aempty;
  assign afull_n  = !afull;
endmodule

// File: rtl/dcfifo_prog_checker.sv
module dcfifo_prog_checker #(
  parameter int DEPTH = 256,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          load_n,
  input logic          oe_n,
  input logic [17:0]   dout,
  input logic          empty_n,
  input logic          full_n,
  input logic          aempty_n,
  input logic          afull_n,
  input logic [PW-1:0] w_bin,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] w_cnt,
  input logic [PW-1:0] r_bin,
  input logic [PW-1:0] r_gray
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && load_n) |=> $stable(w_bin));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && load_n) |=> $stable(r_bin));

  assert_dout_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && load_n && !oe_n) |=> (oe_n || $stable(dout)));

  assert_count_bound_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    w_cnt <= PW'(DEPTH));

  assert_wgray_step_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(w_gray ^ $past(w_gray)));

  assert_rgray_step_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(r_gray ^ $past(r_gray)));

  assert_aempty_on_empty_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  assert_afull_on_full_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
endmodule

bind dcfifo_prog dcfifo_prog_checker #(.DEPTH(DEPTH)) i_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .load_n(load_n), .oe_n(oe_n), .dout(dout),
  .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n),
  .w_bin(w_bin), .w_gray(w_gray), .w_cnt(w_cnt), .r_bin(r_bin), .r_gray(r_gray)
);

// File: tb/test_dcfifo_prog.sv
`timescale 1ns/1ps
module test_dcfifo_prog;
  localparam int DEPTH = 256;

  logic wr_clk = 0, rd_clk = 0;
  logic rst_n = 0, wr_en_n = 1, rd_en_n = 1, load_n = 1, oe_n = 0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic empty_n, full_n, half_n, aempty_n, afull_n;

  always #5    wr_clk = ~wr_clk;
  always #6.5  rd_clk = ~rd_clk;

  dcfifo_prog #(.DEPTH(DEPTH)) i_dcfifo_prog (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .load_n(load_n), .oe_n(oe_n), .din(din), .dout(dout),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  int checks = 0, fails = 0;
  int seq = 0;
  int accepted;
  logic exp_pop = 0;
  logic [17:0] sb_q[$];
  logic [17:0] last_word = '0;

  task automatic check(input logic ok, input string tag, input logic [17:0] act,
                       input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pattern(input int n);
    return 18'h15A5A ^ {n[5:0], n[11:0]};
  endfunction

  // Driver: writes n strobes, pushes only the words the bench expects to be stored.
  task automatic write_words(input int n);
    accepted = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en_n = 0;
      if (full_n) begin
        din = pattern(seq);
        sb_q.push_back(din);
        seq++;
        accepted++;
      end else begin
        din = 18'h3FFFF;
      end
    end
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic read_words(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      if (empty_n) begin
        rd_en_n = 0; exp_pop = 1; got++;
      end else begin
        rd_en_n = 1; exp_pop = 0;
      end
    end
    @(negedge rd_clk);
    rd_en_n = 1; exp_pop = 0;
  endtask

  // Monitor: compares each popped word against the scoreboard.
  always @(posedge rd_clk) begin
    if (exp_pop) begin
      #3;
      if (sb_q.size() == 0) check(1'b0, "R2 unexpected word", dout, 18'h0);
      else begin
        logic [17:0] e;
        e = sb_q.pop_front();
        check(dout == e, "R2 order", dout, e);
        last_word = e;
      end
    end
  end

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic load_offsets(input logic [11:0] v);
    @(negedge wr_clk);
    load_n = 0; wr_en_n = 0; din = {6'h2A, v};
    @(negedge wr_clk);
    wr_en_n = 1; din = 18'h00BAD;
  endtask

  task automatic readback(input logic [11:0] e0, input logic [11:0] e1);
    @(negedge rd_clk);
    load_n = 0; rd_en_n = 0;
    @(posedge rd_clk); #3;
    check(dout == {6'h0, e0}, "R10 readback first", dout, {6'h0, e0});
    @(posedge rd_clk); #3;
    check(dout == {6'h0, e1}, "R10 readback second", dout, {6'h0, e1});
    @(negedge rd_clk);
    rd_en_n = 1; load_n = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: strobes during reset must store nothing
    wr_en_n = 0; rd_en_n = 0; din = 18'h12345;
    repeat (10) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    wr_en_n = 1; rd_en_n = 1;
    @(negedge wr_clk);
    rst_n = 1;
    settle();
    check(empty_n == 0, "R1 empty_n", {17'h0, empty_n}, 18'h0);
    check(full_n == 1 && half_n == 1 && afull_n == 1, "R1 write flags",
          {15'h0, full_n, half_n, afull_n}, 18'h7);
    check(aempty_n == 0, "R1 aempty_n", {17'h0, aempty_n}, 18'h0);
    check(dout == 0, "R1 dout", dout, 18'h0);

    // R7: default empty offset 7
    write_words(7); settle();
    check(aempty_n == 0, "R7 count 7", {17'h0, aempty_n}, 18'h0);
    check(empty_n == 1, "R5 not empty", {17'h0, empty_n}, 18'h1);
    write_words(1); settle();
    check(aempty_n == 1, "R7 count 8", {17'h0, aempty_n}, 18'h1);
    read_words(8); settle();
    check(empty_n == 0, "R5 drained", {17'h0, empty_n}, 18'h0);

    // R4: reads on empty hold the last word
    @(negedge rd_clk); rd_en_n = 0;
    repeat (4) @(negedge rd_clk);
    rd_en_n = 1;
    check(dout == last_word, "R4 hold", dout, last_word);
    settle();

    // R6, R8, R3, R5: fill phase
    write_words(128); settle();
    check(half_n == 1, "R6 count 128", {17'h0, half_n}, 18'h1);
    write_words(1); settle();
    check(half_n == 0, "R6 count 129", {17'h0, half_n}, 18'h0);
    write_words(119); settle();
    check(afull_n == 1, "R8 count 248", {17'h0, afull_n}, 18'h1);
    write_words(1); settle();
    check(afull_n == 0, "R8 count 249", {17'h0, afull_n}, 18'h0);
    check(full_n == 1, "R5 not full 249", {17'h0, full_n}, 18'h1);
    write_words(10); settle();
    check(accepted == 7, "R3 accepted", 18'(accepted), 18'd7);
    check(full_n == 0, "R5 full", {17'h0, full_n}, 18'h0);
    read_words(DEPTH); settle();
    check(empty_n == 0 && sb_q.size() == 0, "R3 drain complete",
          18'(sb_q.size()), 18'h0);

    // R9, R10: program offsets with a no-op edge in between
    load_offsets(12'd20);
    load_offsets(12'd30);
    @(negedge wr_clk); load_n = 1;
    settle();
    readback(12'd20, 12'd30);
    // R9: sequence continues across load high and wraps
    load_offsets(12'd40);
    @(negedge wr_clk); load_n = 1;
    load_offsets(12'd50);
    load_offsets(12'd60);
    @(negedge wr_clk); load_n = 1;
    settle();
    readback(12'd60, 12'd50);

    // R7 with programmed offset 60
    write_words(60); settle();
    check(aempty_n == 0, "R7 prog count 60", {17'h0, aempty_n}, 18'h0);
    write_words(1); settle();
    check(aempty_n == 1, "R7 prog count 61", {17'h0, aempty_n}, 18'h1);
    check(afull_n == 1, "R8 prog count 61", {17'h0, afull_n}, 18'h1);
    read_words(61); settle();

    // R11: output enable gate
    @(negedge rd_clk); oe_n = 1;
    @(negedge rd_clk);
    check(dout == 0, "R11 gated", dout, 18'h0);
    oe_n = 0;
    @(negedge rd_clk);
    check(dout == last_word, "R11 restored", dout, last_word);

    finish_run();
  end
endmodule